// File: doc/BRIEF.md
# Packed Single-Precision Compare Unit

This block compares IEEE-754 single-precision values held in two 128-bit operands, four 32-bit floats each. A 4-bit predicate code selects one of twelve conditions. The block has two kinds of result. Mask results are one word per lane, either all ones or all zeros. Flag results are a small status vector taken from the lowest lane pair. NaN operands, signed zeros, infinities and denormals are all resolved from the bit patterns alone. Denormals are compared as they are and are never flushed to zero.

A two-bit mode input selects the operation:
- **Packed mask:** all four lanes are compared.
- **Scalar mask:** only lane 0 is compared. The upper lanes copy the first operand.
- **Ordered flag compare** and **unordered flag compare:** both produce the same flag pattern.

An operation is accepted on any rising edge where `in_valid` is high. Its result appears, together with a one-cycle `out_valid` pulse, on the following rising edge. A new operation can be issued on every cycle.

Top module: `pkcmp_unit`

## Requirements
- R1: In packed mode (mode 0), lane i of `out_mask` is 32'hFFFFFFFF when the predicate holds for the pair (a lane i, b lane i) and 32'h0 otherwise. Each lane is decided independently of the others. Predicate codes are: 0 equal, 1 less, 2 less-or-equal, 3 greater, 4 greater-or-equal, 5 unordered, 6 not-equal, 7 not-less, 8 not-less-or-equal, 9 not-greater, 10 not-greater-or-equal, 11 ordered. Each relation reads as "a relation b".
- R2: Predicate codes 12 to 15 give an all-zeros lane result in both mask modes.
- R3: A pair is unordered when either value has exponent 8'hFF and a non-zero fraction. For an unordered pair, codes 0–4 and 11 are false, and codes 5–10 are true.
- R4: +0 and -0 compare equal. Denormals are ordered by their true value. Infinities are larger or smaller than every finite value, according to their sign.
- R5: In scalar mode (mode 1), lane 0 holds the predicate mask for the lane-0 pair. Lanes 1–3 equal the corresponding lanes of `in_a`. The upper lanes of `in_b` have no effect.
- R6: In flag modes (modes 2 and 3), the lane-0 pair sets `out_flags`. Bit 2 is zero, bit 1 is parity and bit 0 is carry. The {zero, parity, carry} pattern is 111 for unordered, 100 for equal, 001 for less and 000 for greater. `out_mask` is all zeros in these modes.
- R7: Modes 2 and 3 give identical flags for identical operands. Bits 5 (auxiliary carry), 4 (overflow) and 3 (sign) of `out_flags` are always 0. In mask modes, `out_flags` is all zeros.
- R8: Operands are captured on a rising edge with `in_valid` high. `out_valid` is high for exactly the cycle after the next rising edge, and the result is present in that cycle. When no result is delivered, `out_mask` and `out_flags` keep their last values.
- R9: While `rst_n` is low on a rising edge, `out_valid`, `out_mask` and `out_flags` become zero.
- R10: Operations issued on consecutive cycles each produce their own result on consecutive cycles, including when mask and flag modes alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request, operands captured when high |
| in_mode | input | 2 | 0 packed mask, 1 scalar mask, 2 ordered flags, 3 unordered flags |
| in_pred | input | 4 | Predicate code for mask modes |
| in_a | input | 128 | First operand, four floats, lane 0 in bits 31:0 |
| in_b | input | 128 | Second operand, same layout |
| out_valid | output | 1 | Result valid pulse |
| out_mask | output | 128 | Lane masks, or pass-through upper lanes in scalar mode |
| out_flags | output | 6 | {aux, overflow, sign, zero, parity, carry} |

## Verification
Because the unit is pipelined, a flag-mode compare and a mask-mode compare can be in flight together. The older operation produces its result on the same edge that captures the newer one. The bench provokes this by issuing a flag compare and then a packed compare on adjacent cycles. It then checks that the two outputs arrive on consecutive cycles and that each has the other mode's field cleared: zero mask for the flag result, zero flags for the mask result. The sweeps of special values reach a NaN-versus-signed-zero pair in one lane while the other lanes of the same operation hold ordered pairs. Each lane is judged against a model of its own that works on an integer ordering key.

// File: rtl/pkcmp_pkg.sv
// Package: shared types for the packed single-precision compare unit.
// Assumes binary32 lane layout (sign 31, exponent 30:23, fraction 22:0).
package pkcmp_pkg;

    localparam int SP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FLAG_W = 6;

    // flag vector bit positions
    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_ZF = 2;
    localparam int FL_SF = 3;
    localparam int FL_OF = 4;
    localparam int FL_AF = 5;

    typedef enum logic [1:0] {
        MODE_PACKED     = 2'd0,
        MODE_SCALAR     = 2'd1,
        MODE_FLAG_ORD   = 2'd2,
        MODE_FLAG_UNORD = 2'd3
    } cmp_mode_e;

    typedef enum logic [3:0] {
        PR_EQ    = 4'd0,
        PR_LT    = 4'd1,
        PR_LE    = 4'd2,
        PR_GT    = 4'd3,
        PR_GE    = 4'd4,
        PR_UNORD = 4'd5,
        PR_NEQ   = 4'd6,
        PR_NLT   = 4'd7,
        PR_NLE   = 4'd8,
        PR_NGT   = 4'd9,
        PR_NGE   = 4'd10,
        PR_ORD   = 4'd11
    } pred_e;

    // relation of one lane pair; at most one of the three is set
    typedef struct packed {
        logic unord;
        logic eq;
        logic lt;
    } rel_t;

    // true when the value is any NaN
    function automatic logic sp_is_nan(input logic [SP_W-1:0] v);
        return (v[SP_W-2 -: EXP_W] == {EXP_W{1'b1}}) && (v[FRAC_W-1:0] != '0);
    endfunction

    // true for +0 or -0
    function automatic logic sp_is_zero(input logic [SP_W-1:0] v);
        return v[SP_W-2:0] == '0;
    endfunction

endpackage

// File: rtl/pkcmp_lane.sv
// Module: pkcmp_lane
// Resolves the relation of one binary32 pair (a versus b) into
// unordered / equal / less. Works on raw encodings: signed zeros are
// merged, denormals and infinities fall out of sign-magnitude order.
// Assumes nothing about operand class; purely combinational.
module pkcmp_lane
    import pkcmp_pkg::*;
(
    input  logic [SP_W-1:0] a,
    input  logic [SP_W-1:0] b,
    output rel_t            rel
);

    logic a_nan, b_nan, any_nan;
    logic both_zero, same_val;
    logic a_neg, b_neg;
    logic mag_a_lt_b, mag_b_lt_a;
    logic lt_raw;

    // classify each operand
    always_comb begin
        a_nan     = sp_is_nan(a);
        b_nan     = sp_is_nan(b);
        any_nan   = a_nan | b_nan;
        both_zero = sp_is_zero(a) & sp_is_zero(b);
        same_val  = (a == b) | both_zero;
        a_neg     = a[SP_W-1];
        b_neg     = b[SP_W-1];
    end

    // magnitude comparisons on exponent:fraction
    always_comb begin
        mag_a_lt_b = a[SP_W-2:0] < b[SP_W-2:0];
        mag_b_lt_a = b[SP_W-2:0] < a[SP_W-2:0];
    end

    // sign-magnitude ordering for ordered, distinct values
    always_comb begin
        if (a_neg != b_neg) begin
            lt_raw = a_neg;
        end else if (a_neg) begin
            lt_raw = mag_b_lt_a;
        end else begin
            lt_raw = mag_a_lt_b;
        end
    end

    // final relation record
    always_comb begin
        rel.unord = any_nan;
        rel.eq    = !any_nan & same_val;
        rel.lt    = !any_nan & !same_val & lt_raw;
    end

endmodule

// File: rtl/pkcmp_predicate.sv
// Module: pkcmp_predicate
// Evaluates one of the twelve compare predicates on a lane relation.
// Negated forms are true on unordered pairs; codes 12..15 are false.
module pkcmp_predicate
    import pkcmp_pkg::*;
(
    input  rel_t  rel,
    input  pred_e pred,
    output logic  hit
);

    logic gt, le, ge;

    // derived ordered relations
    always_comb begin
        gt = !rel.unord & !rel.eq & !rel.lt;
        le = rel.lt | rel.eq;
        ge = gt | rel.eq;
    end

    // predicate selection
    always_comb begin
        case (pred)
            PR_EQ:    hit = rel.eq;
            PR_LT:    hit = rel.lt;
            PR_LE:    hit = le;
            PR_GT:    hit = gt;
            PR_GE:    hit = ge;
            PR_UNORD: hit = rel.unord;
            PR_NEQ:   hit = !rel.eq;
            PR_NLT:   hit = !rel.lt;
            PR_NLE:   hit = !le;
            PR_NGT:   hit = !gt;
            PR_NGE:   hit = !ge;
            PR_ORD:   hit = !rel.unord;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pkcmp_flagenc.sv
// Module: pkcmp_flagenc
// Encodes a lane relation into the status-flag vector used by the flag
// compare modes. Only zero, parity and carry can be set.
module pkcmp_flagenc
    import pkcmp_pkg::*;
(
    input  rel_t              rel,
    output logic [FLAG_W-1:0] flags
);

    // build the flag word from the relation
    always_comb begin
        flags        = '0;
        flags[FL_ZF] = rel.unord | rel.eq;
        flags[FL_PF] = rel.unord;
        flags[FL_CF] = rel.unord | rel.lt;
    end

endmodule

// File: rtl/pkcmp_unit.sv
// Module: pkcmp_unit (top)
// Packed / scalar single-precision compare with mask or flag results.
// Stage 1 registers the request; stage 2 registers the result, so a
// result appears one edge after capture. Accepts a request every cycle.
// Assumes LANES >= 1; lane 0 occupies the low 32 bits of each operand.
module pkcmp_unit
    import pkcmp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             in_mode,
    input  logic [3:0]             in_pred,
    input  logic [LANES*SP_W-1:0]  in_a,
    input  logic [LANES*SP_W-1:0]  in_b,
    output logic                   out_valid,
    output logic [LANES*SP_W-1:0]  out_mask,
    output logic [FLAG_W-1:0]      out_flags
);

    localparam int VW = LANES * SP_W;

    logic            v_q;
    cmp_mode_e       mode_q;
    pred_e           pred_q;
    logic [VW-1:0]   a_q;
    logic [VW-1:0]   b_q;

    rel_t            rel   [LANES];
    logic [LANES-1:0] hit;
    logic [VW-1:0]   packed_mask;
    logic [VW-1:0]   mask_next;
    logic [FLAG_W-1:0] lane0_flags;
    logic [FLAG_W-1:0] flags_next;

    // stage 1: capture the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            mode_q <= MODE_PACKED;
            pred_q <= PR_EQ;
            a_q    <= '0;
            b_q    <= '0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                mode_q <= cmp_mode_e'(in_mode);
                pred_q <= pred_e'(in_pred);
                a_q    <= in_a;
                b_q    <= in_b;
            end
        end
    end

    // per-lane relation, predicate and mask expansion
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        pkcmp_lane u_lane (
            .a   (a_q[gi*SP_W +: SP_W]),
            .b   (b_q[gi*SP_W +: SP_W]),
            .rel (rel[gi])
        );

        pkcmp_predicate u_pred (
            .rel  (rel[gi]),
            .pred (pred_q),
            .hit  (hit[gi])
        );

        assign packed_mask[gi*SP_W +: SP_W] = {SP_W{hit[gi]}};
    end

    // flag encoding from the lowest lane
    pkcmp_flagenc u_flags (
        .rel   (rel[0]),
        .flags (lane0_flags)
    );

    // select the result word by mode
    always_comb begin
        mask_next  = '0;
        flags_next = '0;
        case (mode_q)
            MODE_PACKED: begin
                mask_next = packed_mask;
            end
            MODE_SCALAR: begin
                mask_next             = a_q;
                mask_next[SP_W-1:0]   = packed_mask[SP_W-1:0];
            end
            MODE_FLAG_ORD, MODE_FLAG_UNORD: begin
                flags_next = lane0_flags;
            end
            default: begin
                mask_next  = '0;
                flags_next = '0;
            end
        endcase
    end

    // stage 2: register the result, hold when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= v_q;
            if (v_q) begin
                out_mask  <= mask_next;
                out_flags <= flags_next;
            end
        end
    end

endmodule

// File: rtl/pkcmp_unit_chk.sv
// Module: pkcmp_unit_chk
// Port-level temporal checks for pkcmp_unit, attached by bind.
module pkcmp_unit_chk
    import pkcmp_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [1:0]             in_mode,
    input logic [3:0]             in_pred,
    input logic [LANES*SP_W-1:0]  in_a,
    input logic                   out_valid,
    input logic [LANES*SP_W-1:0]  out_mask,
    input logic [FLAG_W-1:0]      out_flags
);

    localparam int VW = LANES * SP_W;

    // R8
    result_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R8
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R7
    upper_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_flags[FL_AF:FL_SF] == '0);

    // R6
    flag_pattern_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_flags[FL_ZF:FL_CF] inside {3'b111, 3'b100, 3'b001, 3'b000}));

    // R6
    flag_mode_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode[1]) |=> ##1 (out_mask == '0));

    // R7
    mask_mode_flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode[1]) |=> ##1 (out_flags == '0));

    // R5
    scalar_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd1) |=>
            ##1 (out_mask[VW-1:SP_W] == $past(in_a[VW-1:SP_W], 2)));

    // R2
    reserved_pred_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode[1] && in_pred >= 4'd12) |=> ##1 (out_mask[SP_W-1:0] == '0));

    // R1
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane_chk
        lane_mask_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_mode == 2'd0) |=> ##1
                (out_mask[gi*SP_W +: SP_W] == '0 || out_mask[gi*SP_W +: SP_W] == '1));
    end

endmodule

bind pkcmp_unit pkcmp_unit_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_pred   (in_pred),
    .in_a      (in_a),
    .out_valid (out_valid),
    .out_mask  (out_mask),
    .out_flags (out_flags)
);

// File: tb/pkcmp_unit_tb.sv
`timescale 1ns/1ps
// Bench: sweeps a table of special binary32 values through every
// predicate and mode; expectations come from an integer ordering key.
module pkcmp_unit_tb;

    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_mode = '0;
    logic [3:0]   in_pred = '0;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic [127:0] out_mask;
    logic [5:0]   out_flags;

    int checks = 0;
    int fails  = 0;
    logic [31:0] vals [NV];

    always #10 clk = ~clk;

    pkcmp_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_pred   (in_pred),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_mask  (out_mask),
        .out_flags (out_flags)
    );

    function automatic bit m_nan(logic [31:0] v);
        return v[30:23] == 8'hFF && v[22:0] != 0;
    endfunction

    // signed key: -0 and +0 both map to 0
    function automatic longint m_key(logic [31:0] v);
        longint m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    function automatic bit m_pred(logic [31:0] a, logic [31:0] b, int p);
        longint ka = m_key(a);
        longint kb = m_key(b);
        if (m_nan(a) || m_nan(b)) return (p >= 5 && p <= 10);
        case (p)
            0: return ka == kb;
            1: return ka <  kb;
            2: return ka <= kb;
            3: return ka >  kb;
            4: return ka >= kb;
            5: return 1'b0;
            6: return ka != kb;
            7: return ka >= kb;
            8: return ka >  kb;
            9: return ka <= kb;
            10: return ka < kb;
            11: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [5:0] m_flags(logic [31:0] a, logic [31:0] b);
        if (m_nan(a) || m_nan(b)) return 6'b000111;
        if (m_key(a) == m_key(b)) return 6'b000100;
        if (m_key(a) <  m_key(b)) return 6'b000001;
        return 6'b000000;
    endfunction

    function automatic string m_tag(logic [31:0] a, logic [31:0] b, int p);
        if (p >= 12) return "R2";
        if (m_nan(a) || m_nan(b)) return "R3";
        if (a[30:23] == 0 || b[30:23] == 0 || a[30:23] == 8'hFF || b[30:23] == 8'hFF) return "R4";
        return "R1";
    endfunction

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one operation alone and wait until its result is visible
    task automatic run_op(logic [1:0] mode, logic [3:0] pred, logic [127:0] a, logic [127:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_mode = mode; in_pred = pred; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [127:0] a, b, held;
        vals[0]  = 32'h0000_0000;  // +0
        vals[1]  = 32'h8000_0000;  // -0
        vals[2]  = 32'h3F80_0000;  // +1
        vals[3]  = 32'hBF80_0000;  // -1
        vals[4]  = 32'h4000_0000;  // +2
        vals[5]  = 32'hC000_0000;  // -2
        vals[6]  = 32'h0000_0001;  // +min denormal
        vals[7]  = 32'h807F_FFFF;  // -max denormal
        vals[8]  = 32'h7F80_0000;  // +inf
        vals[9]  = 32'hFF80_0000;  // -inf
        vals[10] = 32'h7FC0_0000;  // quiet NaN
        vals[11] = 32'hFF80_0001;  // negative signalling NaN

        // R9: reset state, with garbage on inputs
        in_valid = 1'b1; in_a = '1; in_b = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 0 && out_mask == 0 && out_flags == 0, "R9 reset",
              {out_valid, out_flags, out_mask[120:0]}, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R1 R2 R3 R4: packed sweep, all pairs per lane, all codes
        for (int p = 0; p < 16; p++) begin
            for (int i = 0; i < NV; i++) begin
                for (int g = 0; g < 3; g++) begin
                    for (int l = 0; l < 4; l++) begin
                        a[l*32 +: 32] = vals[(i + l) % NV];
                        b[l*32 +: 32] = vals[4*g + l];
                    end
                    run_op(2'd0, 4'(p), a, b);
                    for (int l = 0; l < 4; l++) begin
                        logic [31:0] e;
                        e = {32{m_pred(a[l*32 +: 32], b[l*32 +: 32], p)}};
                        check(out_mask[l*32 +: 32] == e,
                              m_tag(a[l*32 +: 32], b[l*32 +: 32], p),
                              128'(out_mask[l*32 +: 32]), 128'(e));
                    end
                    check(out_flags == 0, "R7 flags zero in mask mode", 128'(out_flags), 0);
                end
            end
        end

        // R5: scalar mode, lane 0 compared, upper lanes from a
        for (int p = 0; p < 16; p += 3) begin
            for (int i = 0; i < NV; i++) begin
                for (int j = 0; j < NV; j++) begin
                    logic [127:0] e;
                    a = {32'hA5A5_0000 + 32'(i), 32'h1234_0000 + 32'(j), vals[j], vals[i]};
                    b = {vals[i], 32'hFFFF_FFFF, 32'(p), vals[j]};
                    e = {a[127:32], {32{m_pred(vals[i], vals[j], p)}}};
                    run_op(2'd1, 4'(p), a, b);
                    check(out_mask == e, "R5 scalar", out_mask, e);
                end
            end
        end

        // R6 R7: flag modes on all pairs, both variants
        for (int i = 0; i < NV; i++) begin
            for (int j = 0; j < NV; j++) begin
                logic [5:0] f_ord;
                a = {vals[j], vals[j], vals[j], vals[i]};
                b = {vals[i], vals[i], vals[i], vals[j]};
                run_op(2'd2, 4'd0, a, b);
                f_ord = out_flags;
                check(out_flags == m_flags(vals[i], vals[j]), "R6 flags",
                      128'(out_flags), 128'(m_flags(vals[i], vals[j])));
                check(out_mask == 0, "R6 mask zero in flag mode", out_mask, 0);
                run_op(2'd3, 4'd7, a, b);
                check(out_flags == f_ord, "R7 unordered variant", 128'(out_flags), 128'(f_ord));
            end
        end

        // R8: single pulse, result held while idle
        run_op(2'd0, 4'd1, {4{vals[3]}}, {4{vals[2]}});
        check(out_valid == 1, "R8 valid pulse", 128'(out_valid), 1);
        held = out_mask;
        @(negedge clk);
        check(out_valid == 0, "R8 pulse ends", 128'(out_valid), 0);
        in_a = '0; in_b = '1; in_pred = 4'd0;
        repeat (3) @(negedge clk);
        check(out_mask == held && held == '1, "R8 hold while idle", out_mask, '1);

        // R10: flag op then packed op back to back
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'd2; in_pred = 4'd0;
        in_a = {4{vals[2]}}; in_b = {4{vals[4]}};
        @(negedge clk);
        in_mode = 2'd0; in_pred = 4'd3;
        in_a = {vals[8], vals[0], vals[10], vals[4]};
        in_b = {vals[2], vals[1], vals[0], vals[2]};
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1 && out_flags == 6'b000001 && out_mask == 0,
              "R10 first (flags)", {out_valid, out_flags, out_mask[120:0]}, {1'b1, 6'b000001, 121'd0});
        @(negedge clk);
        check(out_valid == 1 && out_flags == 0 &&
              out_mask == {32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF},
              "R10 second (mask)", out_mask, {32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF});
        @(negedge clk);
        check(out_valid == 0, "R10 pipeline drains", 128'(out_valid), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule